// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Read Port

This block is the serial slave side of a multi-channel delta-sigma converter. An external controller supplies chip select, serial clock and serial data. A stand-in conversion core runs for a fixed number of system clocks and then hands over a parallel result word. The port reports busy or idle on the data line whenever select is low. It shifts out a 32-bit result frame and takes in a 6-bit channel address at the same time. When the frame has been read, or when select is raised early, it starts the next conversion.

All serial inputs pass through two-flop synchronizers into the system clock domain. Edges of the serial clock are detected there, so the serial clock must be several times slower than the system clock. The data output has a separate enable, so that it can drive a shared line as a tri-state pin.

Top module: `adc_sif_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sdo_oe` and `conv_start` are 0 and the channel outputs are all 0. A conversion begins as reset is released.
- R2: `sdo_oe` is the inverse of `cs_n`, two system clocks late because of the synchronizer.
- R3: Outside the data phase, while select is low, `sdo` is 1 during a conversion and 0 during sleep.
- R4: A conversion ends after `CONV_CYCLES` system clocks whatever the select level. The block then sleeps and holds the result word captured at that moment.
- R5: Sleep gives way to the data phase at the first serial-clock rising edge seen while select is low, and only if the serial clock was low when select fell.
- R6: The output frame is 32 bits, most significant first. It is two 0 bits followed by the 30-bit `res_word`, sign bit first. The frame is first shown when the data phase begins, and it advances one bit after each falling serial-clock edge.
- R7: The 32nd falling edge ends the read. `conv_start` pulses for exactly one clock and `sdo` returns to 1.
- R8: Raising select after the first rising edge and before the 32nd falling edge aborts the read and starts a conversion at once.
- R9: The first six sampled input bits are, in order: enable, single-ended, odd, then address bits 2, 1 and 0. They drive `ch_single`, `ch_odd` and `ch_addr` from the next conversion start. This happens only when all six bits arrived before the read ended and the enable bit is 1. Otherwise the previous channel outputs stay as they were.
- R10: Input bits after the sixth have no effect on the channel outputs.
- R11: Serial-clock edges during a conversion are ignored. No data phase begins and no conversion restarts.
- R12: If the serial clock is high when select falls, serial-clock edges during that select period are ignored and the block stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | External serial clock |
| sdi | input | 1 | Serial data in (channel address) |
| res_word | input | RES_W | Result from the conversion core, sign bit at the top |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Drive enable for the serial data out pin |
| conv_start | output | 1 | One-clock pulse when a conversion starts |
| ch_single | output | 1 | Latched single-ended select |
| ch_odd | output | 1 | Latched odd/polarity select |
| ch_addr | output | 3 | Latched channel address |

## Verification
A wrong state register shows at the data pin within two or three system clocks of the select edge that exposes it. It appears as a busy flag where idle was expected, or a frame bit where a status bit belongs. A miscounted frame or address counter appears later, at the end of a read: `conv_start` comes early or late, or the channel outputs change after an abort or a disabled address. For this reason the reference model is compared against every port on every clock, so that the first cycle of divergence is reported.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    localparam int ADDR_BITS = 6;

    // positions inside the synchronized input vector
    localparam int SIG_CS  = 2;
    localparam int SIG_SCK = 1;
    localparam int SIG_SDI = 0;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DATA  = 2'd2
    } sif_state_e;

    typedef struct packed {
        logic       single;
        logic       odd;
        logic [2:0] addr;
    } chan_sel_t;

    // first shifted bit ends up at the top
    typedef struct packed {
        logic      en;
        chan_sel_t sel;
    } addr_word_t;

    function automatic addr_word_t to_addr_word(input logic [ADDR_BITS-1:0] bits);
        return addr_word_t'(bits);
    endfunction

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= din[g];
                stab_q <= meta_q;
            end
        end
        assign dout[g] = stab_q;
    end

endmodule

// File: rtl/adc_sif_conv_timer.sv
module adc_sif_conv_timer #(
    parameter int CONV_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done,
    output logic busy
);

    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy_q) else $error("timer still busy after done"); // R4
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt_q <= LAST)) else $error("timer count overran"); // R4

endmodule

// File: rtl/adc_sif_shifter.sv
module adc_sif_shifter
    import adc_sif_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int RES_W   = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [RES_W-1:0]     res,
    input  logic                 first_rise,
    input  logic                 rise_en,
    input  logic                 fall_en,
    input  logic                 sdi,
    output logic                 sdo_bit,
    output logic [ADDR_BITS-1:0] addr_bits,
    output logic                 addr_full,
    output logic                 at_last
);

    localparam int FCW = $clog2(FRAME_W + 1);
    localparam int RCW = $clog2(ADDR_BITS + 1);
    localparam int PAD = FRAME_W - RES_W;

    logic [FRAME_W-1:0]   frame_q;
    logic [FCW-1:0]       fall_cnt_q;
    logic [RCW-1:0]       rise_cnt_q;
    logic [ADDR_BITS-1:0] addr_q;

    assign sdo_bit   = frame_q[FRAME_W-1];
    assign addr_bits = addr_q;
    assign addr_full = (rise_cnt_q == RCW'(ADDR_BITS));
    assign at_last   = (fall_cnt_q == FCW'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= {{PAD{1'b0}}, res};
        end else if (fall_en) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_cnt_q <= '0;
            rise_cnt_q <= '0;
            addr_q     <= '0;
        end else if (first_rise) begin
            fall_cnt_q <= '0;
            rise_cnt_q <= RCW'(1);
            addr_q     <= {{(ADDR_BITS-1){1'b0}}, sdi};
        end else begin
            if (rise_en && (rise_cnt_q < RCW'(ADDR_BITS))) begin
                addr_q     <= {addr_q[ADDR_BITS-2:0], sdi};
                rise_cnt_q <= rise_cnt_q + 1'b1;
            end
            if (fall_en) begin
                fall_cnt_q <= fall_cnt_q + 1'b1;
            end
        end
    end

    AST_ADDR_CNT_MAX: assert property (@(posedge clk) disable iff (rst)
        rise_cnt_q <= RCW'(ADDR_BITS)) else $error("address counter past field"); // R10
    AST_NO_EXTRA_FALL: assert property (@(posedge clk) disable iff (rst)
        fall_en |-> (fall_cnt_q < FCW'(FRAME_W))) else $error("fall beyond frame"); // R7

endmodule

// File: rtl/adc_sif_top.sv
module adc_sif_top
    import adc_sif_pkg::*;
#(
    parameter int FRAME_W     = 32,
    parameter int CONV_CYCLES = 4096,
    parameter int RES_W       = FRAME_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic [RES_W-1:0] res_word,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             conv_start,
    output logic             ch_single,
    output logic             ch_odd,
    output logic [2:0]       ch_addr
);

    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0] lvl;
    logic       cs_lvl, sck_lvl, sdi_lvl;
    logic       cs_prev_q, sck_prev_q;
    logic       cs_fall, cs_rise, sck_rise, sck_fall;

    sif_state_e state_q, state_d;
    logic       ext_ok_q, mode_now;
    logic       start_now, load, first_rise, rise_en, fall_en;
    logic       tmr_done, tmr_busy;
    logic       sdo_bit, addr_full, at_last;
    logic [ADDR_BITS-1:0] addr_bits;
    addr_word_t addr_w;
    chan_sel_t  ch_q;
    logic       conv_start_q;

    adc_sif_sync #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cs_n, sck, sdi}),
        .dout (lvl)
    );

    assign cs_lvl  = lvl[SIG_CS];
    assign sck_lvl = lvl[SIG_SCK];
    assign sdi_lvl = lvl[SIG_SDI];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_prev_q  <= cs_lvl;
            sck_prev_q <= sck_lvl;
        end
    end

    assign cs_fall  = !cs_lvl && cs_prev_q;
    assign cs_rise  = cs_lvl && !cs_prev_q;
    assign sck_rise = sck_lvl && !sck_prev_q;
    assign sck_fall = !sck_lvl && sck_prev_q;

    // clock mode is decided by the serial clock level at the select edge
    assign mode_now = cs_fall ? !sck_lvl : ext_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_ok_q <= 1'b0;
        end else if (cs_fall) begin
            ext_ok_q <= !sck_lvl;
        end
    end

    adc_sif_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start_now),
        .done  (tmr_done),
        .busy  (tmr_busy)
    );

    adc_sif_shifter #(.FRAME_W(FRAME_W), .RES_W(RES_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .res        (res_word),
        .first_rise (first_rise),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .sdi        (sdi_lvl),
        .sdo_bit    (sdo_bit),
        .addr_bits  (addr_bits),
        .addr_full  (addr_full),
        .at_last    (at_last)
    );

    assign addr_w = to_addr_word(addr_bits);

    always_comb begin
        state_d    = state_q;
        start_now  = 1'b0;
        load       = 1'b0;
        first_rise = 1'b0;
        rise_en    = 1'b0;
        fall_en    = 1'b0;
        unique case (state_q)
            ST_CONV: begin
                if (tmr_done) begin
                    state_d = ST_SLEEP;
                    load    = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!cs_lvl && mode_now && sck_rise) begin
                    state_d    = ST_DATA;
                    first_rise = 1'b1;
                end
            end
            ST_DATA: begin
                if (cs_rise) begin
                    start_now = 1'b1;
                end else begin
                    rise_en = sck_rise;
                    fall_en = sck_fall;
                    if (sck_fall && at_last) begin
                        start_now = 1'b1;
                    end
                end
            end
            default: state_d = ST_CONV;
        endcase
        if (start_now) begin
            state_d = ST_CONV;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_CONV;
            conv_start_q <= 1'b0;
            ch_q         <= '0;
        end else begin
            state_q      <= state_d;
            conv_start_q <= start_now;
            if (start_now && addr_full && addr_w.en) begin
                ch_q <= addr_w.sel;
            end
        end
    end

    assign sdo        = (state_q == ST_DATA) ? sdo_bit : (state_q == ST_CONV);
    assign sdo_oe     = !cs_lvl;
    assign conv_start = conv_start_q;
    assign ch_single  = ch_q.single;
    assign ch_odd     = ch_q.odd;
    assign ch_addr    = ch_q.addr;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start_q |=> !conv_start_q) else $error("start pulse too long"); // R7
    AST_START_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        conv_start_q |-> (state_q == ST_CONV && tmr_busy)) else $error("start without conversion"); // R8
    AST_CH_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_q) |-> conv_start_q) else $error("channel changed outside start"); // R9
    AST_DATA_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && $past(state_q) == ST_SLEEP) |-> ($past(sck_rise) && !$past(cs_lvl)))
        else $error("data phase entered without clock edge"); // R5
    AST_SLEEP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_CONV && $past(tmr_done)) |-> (state_q == ST_SLEEP))
        else $error("no sleep after conversion"); // R4

endmodule

// File: tb/adc_sif_top_tb_top.sv
`timescale 1ns/1ps
module adc_sif_top_tb_top;

    localparam int FW    = 32;
    localparam int RW    = FW - 2;
    localparam int NCONV = 200;
    localparam int H     = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic [RW-1:0] res = 30'h2A5C31E7;
    logic          sdo, sdo_oe, conv_start, ch_single, ch_odd;
    logic [2:0]    ch_addr;

    int n_chk = 0, n_fail = 0, n_starts = 0, cyc = 0;
    bit finished = 0;

    adc_sif_top #(.FRAME_W(FW), .CONV_CYCLES(NCONV)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .res_word(res), .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start),
        .ch_single(ch_single), .ch_odd(ch_odd), .ch_addr(ch_addr)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    logic [2:0]    hist[$];
    int            m_state, m_cnt, m_nf;
    bit            m_ext, m_start, m_oe, m_sdo;
    logic [FW-1:0] m_frame;
    logic [4:0]    m_ch;
    bit            m_addr[$];

    always @(posedge clk) begin
        if (rst) begin
            hist = '{3'b100, 3'b100, 3'b100, 3'b100};
            m_state = 0; m_cnt = 0; m_nf = 0; m_ext = 0; m_start = 0;
            m_ch = '0; m_addr.delete(); m_oe = 0; m_sdo = 1;
        end else begin
            bit c, cp, k, kp, d, cf, cr, kr, kf, mode, fin;
            hist.push_front({cs_n, sck, sdi});
            void'(hist.pop_back());
            c = hist[2][2]; cp = hist[3][2];
            k = hist[2][1]; kp = hist[3][1]; d = hist[2][0];
            cf = !c && cp; cr = c && !cp; kr = k && !kp; kf = !k && kp;
            mode = cf ? !k : m_ext;
            if (cf) m_ext = !k;
            fin = 0; m_start = 0;
            case (m_state)
                0: if (m_cnt == NCONV - 1) begin m_state = 1; m_frame = {2'b00, res}; end
                   else m_cnt++;
                1: if (!c && mode && kr) begin
                       m_state = 2; m_addr.delete(); m_addr.push_back(d); m_nf = 0;
                   end
                default: begin
                    if (cr) fin = 1;
                    else begin
                        if (kr && m_addr.size() < 6) m_addr.push_back(d);
                        if (kf) begin
                            m_nf++; m_frame = m_frame << 1;
                            if (m_nf == FW) fin = 1;
                        end
                    end
                end
            endcase
            if (fin) begin
                if (m_addr.size() == 6 && m_addr[0])
                    m_ch = {m_addr[1], m_addr[2], m_addr[3], m_addr[4], m_addr[5]};
                m_state = 0; m_cnt = 0; m_start = 1;
            end
            m_oe  = !hist[1][2];
            m_sdo = (m_state == 2) ? m_frame[FW-1] : (m_state == 0);
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2", sdo_oe, m_oe, "model sdo_oe");
            if (sdo_oe) chk(m_state == 2 ? "R6" : "R3", sdo, m_sdo, "model sdo");
            chk("R7", conv_start, m_start, "model conv_start");
            chk("R9", {ch_single, ch_odd, ch_addr}, m_ch, "model channel");
        end
    end

    always @(posedge clk) if (!rst && conv_start) n_starts++;

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int nbits, input logic [5:0] a, input logic [31:0] tail,
                      output logic [31:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 6) ? a[5-i] : tail[i];
            tick(H);
            got[FW-1-i] = sdo;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] got, exp;
        tick(5);
        chk("R1", sdo_oe, 0, "oe in reset");
        chk("R1", conv_start, 0, "start in reset");
        chk("R1", {ch_single, ch_odd, ch_addr}, 0, "channel in reset");
        rst = 1'b0;
        tick(1);
        chk("R1", conv_start, 0, "start after reset");
        tick(2);
        cs_n = 1'b0;
        tick(5);
        chk("R2", sdo_oe, 1, "oe with select low");
        chk("R3", sdo, 1, "busy while converting");
        // R11: clock edges during conversion
        repeat (4) begin sck = 1'b1; tick(H); sck = 1'b0; tick(H); end
        chk("R11", sdo, 1, "still converting after clocks");
        chk("R11", n_starts, 0, "no restart from clocks");
        tick(NCONV);
        chk("R4", sdo, 0, "asleep after conversion");
        // full read
        exp = {2'b00, res};
        rd(32, 6'b110101, 32'hDEADBEEF, got);
        chk("R6", got, exp, "full frame");
        tick(6);
        chk("R7", sdo, 1, "busy after 32nd fall");
        chk("R7", n_starts, 1, "one start after read");
        chk("R10", {ch_single, ch_odd, ch_addr}, 5'b10101, "channel from first six bits");
        res = 30'h15A3C0DE;
        tick(NCONV + 10);
        chk("R4", sdo, 0, "asleep again");
        // abort after address complete
        exp = {2'b00, res};
        rd(10, 6'b101011, 32'h0, got);
        cs_n = 1'b1;
        tick(6);
        chk("R8", n_starts, 2, "abort starts conversion");
        chk("R9", {ch_single, ch_odd, ch_addr}, 5'b01011, "complete address on abort");
        chk("R6", got[31:22], exp[31:22], "partial frame");
        cs_n = 1'b0;
        tick(5);
        chk("R8", sdo, 1, "converting after abort");
        cs_n = 1'b1;
        res = 30'h0F0F1234;
        tick(NCONV + 10);
        cs_n = 1'b0;
        tick(5);
        chk("R4", sdo, 0, "sleep reached with select high");
        // abort before A0
        rd(4, 6'b111111, 32'h0, got);
        cs_n = 1'b1;
        tick(6);
        chk("R8", n_starts, 3, "early abort starts conversion");
        chk("R9", {ch_single, ch_odd, ch_addr}, 5'b01011, "short address discarded");
        tick(NCONV + 10);
        cs_n = 1'b0;
        tick(5);
        // enable bit clear
        exp = {2'b00, res};
        rd(32, 6'b011100, 32'hFFFFFFFF, got);
        tick(6);
        chk("R9", {ch_single, ch_odd, ch_addr}, 5'b01011, "disabled address ignored");
        chk("R6", got, exp, "second full frame");
        chk("R7", n_starts, 4, "start after full read");
        cs_n = 1'b1;
        tick(4);
        chk("R2", sdo_oe, 0, "released with select high");
        tick(NCONV + 10);
        // select falls with the clock high
        sck = 1'b1;
        tick(5);
        cs_n = 1'b0;
        tick(5);
        repeat (4) begin sck = 1'b0; tick(H); sck = 1'b1; tick(H); end
        chk("R12", sdo, 0, "still asleep in wrong clock mode");
        chk("R12", n_starts, 4, "no read in wrong clock mode");
        sck = 1'b0;
        tick(4);
        cs_n = 1'b1;
        tick(5);
        cs_n = 1'b0;
        tick(5);
        rd(32, 6'b100010, 32'h0, got);
        tick(6);
        chk("R5", got, exp, "read after proper select");
        chk("R5", {ch_single, ch_odd, ch_addr}, 5'b00010, "address after proper select");
        chk("R7", n_starts, 5, "start after last read");
        tick(4);
        summary();
    end

endmodule